// File: doc/BRIEF.md
# Lock-In Reference Phase Auto-Alignment Controller

This block sets and then holds the phase offset that a lock-in demodulator's reference oscillator adds to its phase, so that the coherent signal lands on the in-phase (I) axis and the quadrature (Q) output sits near zero. It drives an unsigned phase-offset word to the oscillator. It takes one record per finished demodulator window from the demodulator: a valid strobe, signed I and Q results, and an overload flag.

Two modes share the same phase register. A sweep is an open-loop calibration pass. It visits a programmable series of offsets, takes one accepted window at each, and then parks the offset on the point with the largest I. At the end it reports whether that point lies inside an allowed window, which exposes gross delay or polarity faults. The servo is a closed loop that tracks slow drift. For every accepted window it moves the offset one step in the direction given by the sign of Q, and it halves the step each time the sign flips. A settle counter throws away a programmable number of windows after each phase write. Windows flagged as overloaded are never used. Servo windows whose |I| is below a floor do not move the phase. The signed amount of the latest correction is kept on an output so it can be logged as an aging indicator.

Top module: `phase_align_ctrl`

## Requirements
- R1: After reset, phase_off is 0, done is 0, win_fault is 0 and last_corr is 0.
- R2: A rising edge of run with mode_servo=0 starts a sweep. phase_off becomes sweep_base, and each accepted window moves it by sweep_inc, modulo 2^PW. The sweep covers max(sweep_pts,1) points.
- R3: After the last sweep point, phase_off holds the visited offset with the largest signed I. A tie in I goes to the smaller |Q|, and a full tie goes to the earliest point. done rises at the same time.
- R4: win_fault is set at sweep completion when (best − win_lo) mod 2^PW > (win_hi − win_lo) mod 2^PW. It is clear otherwise. It is never set while done is 0.
- R5: After each phase_off write, and after any rising edge of run, the next settle_k valid windows are discarded.
- R6: A window with dm_ovl=1 neither moves phase_off nor counts as a measurement.
- R7: In servo mode (run rising with mode_servo=1), each accepted window with Q>0 adds the current step to phase_off. Q<0 subtracts it. Q=0 leaves phase_off unchanged.
- R8: The servo starts with step_init. On each sign reversal of Q between servo moves, the step is halved before it is applied, but it never goes below step_min. This assumes step_init ≥ step_min.
- R9: A servo window with |I| < min_level (unsigned compare) leaves phase_off unchanged.
- R10: last_corr holds the signed change of the latest servo move. After a sweep it holds the final offset minus the offset held before that sweep started, both modulo 2^PW.
- R11: Phase arithmetic wraps modulo 2^PW through zero without saturation.
- R12: While run is 0, phase_off does not change. A sweep that is abandoned by dropping run leaves done at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Operate while high; a rising edge starts the selected mode |
| mode_servo | input | 1 | Sampled at run rise: 0 sweep, 1 servo |
| sweep_base | input | PW | First sweep offset |
| sweep_inc | input | PW | Offset increment per sweep point (modular) |
| sweep_pts | input | CW | Number of sweep points (0 treated as 1) |
| settle_k | input | KW | Windows discarded after each phase write or start |
| win_lo | input | PW | Lower edge of the allowed peak window |
| win_hi | input | PW | Upper edge of the allowed peak window |
| step_init | input | PW | Initial servo step |
| step_min | input | PW | Servo step floor |
| min_level | input | DW | Minimum |I| for a servo move |
| dm_valid | input | 1 | One-cycle strobe of a finished demodulator window |
| dm_i | input | DW | Signed in-phase result |
| dm_q | input | DW | Signed quadrature result |
| dm_ovl | input | 1 | Window was corrupted by overload |
| phase_off | output | PW | Phase offset to the reference oscillator |
| done | output | 1 | Sweep finished and offset committed |
| win_fault | output | 1 | Committed sweep peak lies outside the window |
| last_corr | output | PW | Signed latest correction |

## Verification
A triangular demodulator model drives the block. In that model, I falls and Q changes sign with the distance between a hidden true phase and phase_off. Random sweeps use random base, increment, point count, settle depth and overload rate, and they are scored against a reference search. Directed sweeps cover the following cases: an I tie settled by |Q|, a full tie kept at the earliest point, wrap through zero, a window that wraps, and a window that excludes the peak. Windows that should be discarded or are overloaded carry a poisoned, maximal I and a large Q. A block that consumed any of them would visibly lock to the wrong point. Servo runs are compared against the exact sequence of signed moves that the halving rule predicts from a fixed start. Further servo runs check that the phase does not move for Q=0, for low signal and for all-overload input.

// File: rtl/phase_align_pkg.sv
package phase_align_pkg;

   // Controller operating state
   typedef enum logic [1:0] {
      PA_IDLE  = 2'd0,
      PA_SWEEP = 2'd1,
      PA_SERVO = 2'd2,
      PA_DONE  = 2'd3
   } pa_state_e;

endpackage

// File: rtl/pa_settle_gate.sv
module pa_settle_gate #(
   parameter int KW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [KW-1:0] settle_k,
   input  logic          reload,
   input  logic          dm_valid,
   input  logic          dm_ovl,
   output logic          win_acc
);

   logic [KW-1:0] skip_q;

   // Count down the windows that still belong to the previous phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q <= '0;
      end else if (reload) begin
         skip_q <= settle_k;
      end else if (dm_valid && (skip_q != '0)) begin
         skip_q <= skip_q - {{(KW-1){1'b0}}, 1'b1};
      end
   end

   assign win_acc = dm_valid && (skip_q == '0) && !dm_ovl;

endmodule

// File: rtl/pa_peak_track.sv
module pa_peak_track #(
   parameter int PW       = 16,
   parameter int DW       = 16,
   parameter bit TIE_ON_Q = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 upd,
   input  logic [PW-1:0]        cur_ph,
   input  logic signed [DW-1:0] cur_i,
   input  logic signed [DW-1:0] cur_q,
   output logic                 cand_wins,
   output logic [PW-1:0]        best_ph
);

   logic signed [DW-1:0] best_i_q;
   logic [DW-1:0]        best_aq_q;
   logic [PW-1:0]        best_ph_q;
   logic                 best_vld_q;
   logic signed [DW-1:0] neg_q;
   logic [DW-1:0]        cur_aq;
   logic                 tie_better;

   assign neg_q  = -cur_q;
   assign cur_aq = cur_q[DW-1] ? $unsigned(neg_q) : $unsigned(cur_q);

   // Variant: quadrature magnitude breaks ties in I, or first point wins
   generate
      if (TIE_ON_Q) begin : g_tie_q
         assign tie_better = (cur_i == best_i_q) && (cur_aq < best_aq_q);
      end else begin : g_tie_first
         assign tie_better = 1'b0;
      end
   endgenerate

   assign cand_wins = !best_vld_q || (cur_i > best_i_q) || tie_better;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_vld_q <= 1'b0;
         best_i_q   <= '0;
         best_aq_q  <= '0;
         best_ph_q  <= '0;
      end else if (clr) begin
         best_vld_q <= 1'b0;
      end else if (upd && cand_wins) begin
         best_vld_q <= 1'b1;
         best_i_q   <= cur_i;
         best_aq_q  <= cur_aq;
         best_ph_q  <= cur_ph;
      end
   end

   assign best_ph = best_ph_q;

endmodule

// File: rtl/pa_servo_step.sv
module pa_servo_step #(
   parameter int PW       = 16,
   parameter bit HALVE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic          q_neg,
   input  logic [PW-1:0] step_init,
   input  logic [PW-1:0] step_min,
   output logic [PW-1:0] step_now
);

   logic [PW-1:0] step_q;
   logic          last_neg_q;
   logic          have_dir_q;
   logic          reversal;
   logic [PW-1:0] halved;

   assign reversal = have_dir_q && (q_neg != last_neg_q);
   assign halved   = step_q >> 1;

   // Variant: binary-search step shrink, or fixed step
   generate
      if (HALVE_EN) begin : g_halve
         assign step_now = !reversal        ? step_q   :
                           (halved < step_min) ? step_min : halved;
      end else begin : g_fixed
         assign step_now = step_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= '0;
         last_neg_q <= 1'b0;
         have_dir_q <= 1'b0;
      end else if (clr) begin
         step_q     <= step_init;
         last_neg_q <= 1'b0;
         have_dir_q <= 1'b0;
      end else if (upd) begin
         step_q     <= step_now;
         last_neg_q <= q_neg;
         have_dir_q <= 1'b1;
      end
   end

   AST_STEP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && (step_q >= step_min)) |=> (step_q <= $past(step_q))); // R8

   AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && (step_q >= step_min)) |=> (step_q >= $past(step_min))); // R8

endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl
   import phase_align_pkg::*;
#(
   parameter int PW       = 16,
   parameter int DW       = 16,
   parameter int KW       = 4,
   parameter int CW       = 8,
   parameter bit TIE_ON_Q = 1'b1,
   parameter bit HALVE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 mode_servo,
   input  logic [PW-1:0]        sweep_base,
   input  logic [PW-1:0]        sweep_inc,
   input  logic [CW-1:0]        sweep_pts,
   input  logic [KW-1:0]        settle_k,
   input  logic [PW-1:0]        win_lo,
   input  logic [PW-1:0]        win_hi,
   input  logic [PW-1:0]        step_init,
   input  logic [PW-1:0]        step_min,
   input  logic [DW-1:0]        min_level,
   input  logic                 dm_valid,
   input  logic signed [DW-1:0] dm_i,
   input  logic signed [DW-1:0] dm_q,
   input  logic                 dm_ovl,
   output logic [PW-1:0]        phase_off,
   output logic                 done,
   output logic                 win_fault,
   output logic signed [PW-1:0] last_corr
);

   localparam logic [CW:0] IDX_ONE = {{CW{1'b0}}, 1'b1};

   // Elaboration-time parameter checks
   generate
      if (PW < 4 || PW > 32) begin : g_bad_pw
         $error("phase_align_ctrl: PW out of range");
      end
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("phase_align_ctrl: DW out of range");
      end
      if (KW < 1 || CW < 1) begin : g_bad_cnt
         $error("phase_align_ctrl: KW and CW must be at least 1");
      end
   endgenerate

   pa_state_e            st_q;
   logic                 run_d_q;
   logic                 run_rise;
   logic [PW-1:0]        ph_q;
   logic [PW-1:0]        pre_ph_q;
   logic [CW-1:0]        idx_q;
   logic [CW:0]          idx_nx;
   logic                 done_q;
   logic                 fault_q;
   logic [PW-1:0]        corr_q;
   logic                 win_acc;
   logic                 sw_acc;
   logic                 sv_acc;
   logic                 sv_move;
   logic                 ph_load;
   logic                 last_pt;
   logic                 cand_wins;
   logic [PW-1:0]        best_ph;
   logic [PW-1:0]        final_ph;
   logic [PW-1:0]        off_lo;
   logic [PW-1:0]        span;
   logic                 in_win;
   logic signed [DW-1:0] neg_i;
   logic [DW-1:0]        abs_i;
   logic                 lvl_ok;
   logic [PW-1:0]        step_now;
   logic [PW-1:0]        servo_next;
   logic [PW-1:0]        servo_corr;

   assign run_rise = run && !run_d_q;

   // Window qualification
   assign sw_acc  = run && win_acc && (st_q == PA_SWEEP);
   assign sv_acc  = run && win_acc && (st_q == PA_SERVO);
   assign neg_i   = -dm_i;
   assign abs_i   = dm_i[DW-1] ? $unsigned(neg_i) : $unsigned(dm_i);
   assign lvl_ok  = abs_i >= min_level;
   assign sv_move = sv_acc && lvl_ok && (dm_q != '0);
   assign ph_load = (run_rise && !mode_servo) || sw_acc || sv_move;

   // Sweep bookkeeping
   assign idx_nx   = {1'b0, idx_q} + IDX_ONE;
   assign last_pt  = idx_nx >= {1'b0, sweep_pts};
   assign final_ph = cand_wins ? ph_q : best_ph;
   assign off_lo   = final_ph - win_lo;
   assign span     = win_hi - win_lo;
   assign in_win   = off_lo <= span;

   // Servo move
   assign servo_next = dm_q[DW-1] ? (ph_q - step_now) : (ph_q + step_now);
   assign servo_corr = dm_q[DW-1] ? ({PW{1'b0}} - step_now) : step_now;

   pa_settle_gate #(.KW(KW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .settle_k (settle_k),
      .reload   (ph_load || run_rise),
      .dm_valid (dm_valid),
      .dm_ovl   (dm_ovl),
      .win_acc  (win_acc)
   );

   pa_peak_track #(.PW(PW), .DW(DW), .TIE_ON_Q(TIE_ON_Q)) u_peak (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (run_rise && !mode_servo),
      .upd       (sw_acc),
      .cur_ph    (ph_q),
      .cur_i     (dm_i),
      .cur_q     (dm_q),
      .cand_wins (cand_wins),
      .best_ph   (best_ph)
   );

   pa_servo_step #(.PW(PW), .HALVE_EN(HALVE_EN)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (run_rise && mode_servo),
      .upd       (sv_move),
      .q_neg     (dm_q[DW-1]),
      .step_init (step_init),
      .step_min  (step_min),
      .step_now  (step_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PA_IDLE;
         run_d_q  <= 1'b0;
         ph_q     <= '0;
         pre_ph_q <= '0;
         idx_q    <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         corr_q   <= '0;
      end else begin
         run_d_q <= run;
         if (!run) begin
            st_q <= PA_IDLE;
         end else if (run_rise) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            if (mode_servo) begin
               st_q <= PA_SERVO;
            end else begin
               st_q     <= PA_SWEEP;
               pre_ph_q <= ph_q;
               ph_q     <= sweep_base;
               idx_q    <= '0;
            end
         end else if (sw_acc) begin
            if (last_pt) begin
               ph_q    <= final_ph;
               st_q    <= PA_DONE;
               done_q  <= 1'b1;
               fault_q <= !in_win;
               corr_q  <= final_ph - pre_ph_q;
            end else begin
               ph_q  <= ph_q + sweep_inc;
               idx_q <= idx_nx[CW-1:0];
            end
         end else if (sv_move) begin
            ph_q   <= servo_next;
            corr_q <= servo_corr;
         end
      end
   end

   assign phase_off = ph_q;
   assign done      = done_q;
   assign win_fault = fault_q;
   assign last_corr = $signed(corr_q);

   AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_load || run_rise) && (settle_k != '0)) |=> !win_acc); // R5

   AST_OVL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_valid && dm_ovl && !run_rise) |=> $stable(phase_off)); // R6

   AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PA_SERVO) && dm_valid && (abs_i < min_level) && !run_rise) |=> $stable(phase_off)); // R9

   AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      win_fault |-> done); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(phase_off)); // R12

   AST_DONE_ONLY_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(st_q == PA_SWEEP)); // R3

endmodule

// File: tb/phase_align_ctrl_tb.sv
module phase_align_ctrl_tb;

   localparam int PW = 16;
   localparam int DW = 16;
   localparam int KW = 4;
   localparam int CW = 8;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 run;
   logic                 mode_servo;
   logic [PW-1:0]        sweep_base, sweep_inc, win_lo, win_hi, step_init, step_min;
   logic [CW-1:0]        sweep_pts;
   logic [KW-1:0]        settle_k;
   logic [DW-1:0]        min_level;
   logic                 dm_valid, dm_ovl;
   logic signed [DW-1:0] dm_i, dm_q;
   logic [PW-1:0]        phase_off;
   logic                 done, win_fault;
   logic signed [PW-1:0] last_corr;

   int checks = 0;
   int fails  = 0;

   // Stub demodulator state
   logic [PW-1:0] theta = '0;
   int            amp = 10000;
   int            ovl_pct = 0;
   int            cur_k = 0;
   bit            want_run = 1'b0;

   always #2.5 clk = ~clk;

   phase_align_ctrl #(.PW(PW), .DW(DW), .KW(KW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .mode_servo(mode_servo),
      .sweep_base(sweep_base), .sweep_inc(sweep_inc), .sweep_pts(sweep_pts),
      .settle_k(settle_k), .win_lo(win_lo), .win_hi(win_hi),
      .step_init(step_init), .step_min(step_min), .min_level(min_level),
      .dm_valid(dm_valid), .dm_i(dm_i), .dm_q(dm_q), .dm_ovl(dm_ovl),
      .phase_off(phase_off), .done(done), .win_fault(win_fault), .last_corr(last_corr)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Triangular model: I falls with |theta - ph|, Q follows its sign
   function automatic void model(input logic [PW-1:0] ph, output int iv, output int qv);
      logic signed [PW-1:0] d;
      int di;
      d  = theta - ph;
      di = int'(d);
      iv = amp - ((di < 0 ? -di : di) / 4);
      qv = di >>> 2;
   endfunction

   function automatic void sweep_ref(input logic [PW-1:0] base, input logic [PW-1:0] inc, input int pts,
                                     input logic [PW-1:0] lo, input logic [PW-1:0] hi, input logic [PW-1:0] pre,
                                     output logic [PW-1:0] bph, output logic flt, output logic [PW-1:0] corr);
      int bi, baq, iv, qv, aq, n;
      logic [PW-1:0] p, a, b;
      n = (pts < 1) ? 1 : pts;
      p = base; bi = 0; baq = 0; bph = base;
      for (int k = 0; k < n; k++) begin
         model(p, iv, qv);
         aq = (qv < 0) ? -qv : qv;
         if (k == 0 || iv > bi || (iv == bi && aq < baq)) begin
            bi = iv; baq = aq; bph = p;
         end
         p = p + inc;
      end
      a = bph - lo;
      b = hi - lo;
      flt = (a > b);
      corr = bph - pre;
   endfunction

   // Demodulator stub and run driver, one process
   initial begin : stub
      logic [PW-1:0] seen_ph;
      int since_chg, tick, iv, qv;
      run = 1'b0; dm_valid = 1'b0; dm_ovl = 1'b0; dm_i = '0; dm_q = '0;
      seen_ph = '0; since_chg = 0; tick = 0;
      forever begin
         @(negedge clk);
         dm_valid = 1'b0;
         dm_ovl   = 1'b0;
         if (phase_off !== seen_ph) begin
            seen_ph = phase_off;
            since_chg = 0;
         end
         if (want_run && !run) begin
            run = 1'b1;
            since_chg = 0;
            tick = 0;
         end else begin
            if (!want_run) run = 1'b0;
            tick++;
            if (tick % 4 == 0) begin
               dm_valid = 1'b1;
               if (since_chg < cur_k) begin
                  dm_i = 16'sd32767; dm_q = 16'sd20000;
               end else if (int'($urandom % 100) < ovl_pct) begin
                  dm_ovl = 1'b1; dm_i = 16'sd32767; dm_q = 16'sd20000;
               end else begin
                  model(phase_off, iv, qv);
                  dm_i = DW'(iv); dm_q = DW'(qv);
               end
               since_chg++;
            end
         end
      end
   end

   task automatic wait_run_low();
      want_run = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic start_run();
      want_run = 1'b1;
      @(posedge run);
      @(negedge clk);
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int c = 0; c < 20000; c++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic cfg_sweep(input logic [PW-1:0] base, input logic [PW-1:0] inc, input int pts,
                            input int k, input logic [PW-1:0] lo, input logic [PW-1:0] hi, input int ovl);
      @(negedge clk);
      mode_servo = 1'b0;
      sweep_base = base; sweep_inc = inc; sweep_pts = CW'(pts);
      settle_k = KW'(k); cur_k = k; win_lo = lo; win_hi = hi; ovl_pct = ovl;
   endtask

   task automatic do_sweep(input string tag, input logic [PW-1:0] base, input logic [PW-1:0] inc, input int pts,
                           input int k, input logic [PW-1:0] lo, input logic [PW-1:0] hi, input int ovl);
      logic [PW-1:0] eph, ecorr, pre;
      logic eflt;
      bit ok;
      cfg_sweep(base, inc, pts, k, lo, hi, ovl);
      pre = phase_off;
      sweep_ref(base, inc, pts, lo, hi, pre, eph, eflt, ecorr);
      start_run();
      chk("R2", {tag, " first offset"}, phase_off, base);
      wait_done(ok);
      chk("R3", {tag, " done"}, done, 1);
      chk("R3", {tag, " best offset"}, phase_off, eph);
      chk("R4", {tag, " window fault"}, win_fault, eflt);
      chk("R10", {tag, " sweep correction"}, last_corr, $signed(ecorr));
      wait_run_low();
   endtask

   task automatic place(input logic [PW-1:0] ph);
      bit ok;
      cfg_sweep(ph, 16'd1, 1, 0, 16'd0, 16'hFFFF, 0);
      start_run();
      wait_done(ok);
      wait_run_low();
   endtask

   task automatic start_servo(input int k, input logic [PW-1:0] s0, input logic [PW-1:0] smin,
                              input int lvl, input int ovl);
      @(negedge clk);
      mode_servo = 1'b1; settle_k = KW'(k); cur_k = k;
      step_init = s0; step_min = smin; min_level = DW'(lvl); ovl_pct = ovl;
      start_run();
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int exp_d[10] = '{256, 256, 256, 256, -128, 64, 64, -32, 16, -16};
      logic [PW-1:0] old, rec, lo_r;
      logic signed [PW-1:0] dd;
      int n, di;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; mode_servo = 1'b0;
      sweep_base = '0; sweep_inc = '0; sweep_pts = '0; settle_k = '0;
      win_lo = '0; win_hi = '0; step_init = 16'd256; step_min = 16'd16; min_level = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "phase_off", phase_off, 0);
      chk("R1", "done", done, 0);
      chk("R1", "win_fault", win_fault, 0);
      chk("R1", "last_corr", last_corr, 0);

      // R11 wrap through zero; full tie keeps earliest (R3)
      theta = 16'h0004; amp = 10000;
      do_sweep("R11 wrap", 16'hFFF0, 16'd8, 5, 0, 16'hFF00, 16'h0100, 0);
      chk("R11", "wrapped peak", phase_off, 16'h0000);

      // R3 tie in I broken by smaller |Q| on a later point
      theta = 16'h3000;
      do_sweep("R3 tiebreak", 16'h3006, 16'hFFF4, 2, 0, 16'h0000, 16'hFFFF, 0);
      chk("R3", "tiebreak offset", phase_off, 16'h2FFA);

      // R4 peak outside window
      theta = 16'h8000;
      do_sweep("R4 outside", 16'h7F00, 16'h0040, 8, 1, 16'h1000, 16'h2000, 0);
      chk("R4", "fault raised", win_fault, 1);

      // R5 deep discard with poisoned settle windows
      theta = 16'h1234;
      do_sweep("R5 discard", 16'h1000, 16'h0100, 6, 3, 16'h1100, 16'h1300, 0);

      // R6 heavy overload in a sweep
      theta = 16'hA000;
      do_sweep("R6 overload", 16'h9C00, 16'h0200, 5, 1, 16'h9000, 16'hB000, 60);

      // Random sweeps
      for (int r = 0; r < 8; r++) begin
         theta = PW'($urandom);
         lo_r  = PW'($urandom);
         do_sweep("R2 random", PW'($urandom), PW'($urandom % 4096) + 16'd1,
                  int'($urandom % 16) + 1, int'($urandom % 4), lo_r,
                  lo_r + PW'($urandom % 16384), int'($urandom % 30));
      end

      // R12 abandoned sweep
      theta = 16'h5000;
      cfg_sweep(16'h4000, 16'h0100, 20, 2, 16'h0, 16'hFFFF, 0);
      start_run();
      repeat (30) @(negedge clk);
      wait_run_low();
      rec = phase_off;
      repeat (60) @(negedge clk);
      chk("R12", "phase held while idle", phase_off, rec);
      chk("R12", "done after abandon", done, 0);

      // R7/R8/R10 servo trajectory
      place(16'h4000);
      theta = 16'h4000 + 16'd1000; amp = 10000;
      start_servo(1, 16'd256, 16'd16, 100, 0);
      old = phase_off; n = 0;
      for (int c = 0; c < 4000 && n < 10; c++) begin
         @(negedge clk);
         if (phase_off != old) begin
            dd = phase_off - old;
            if (n == 0) begin
               chk("R7", "first move direction", int'(dd), 256);
               chk("R10", "first servo correction", last_corr, 256);
            end else begin
               chk("R8", $sformatf("servo move %0d", n), int'(dd), exp_d[n]);
            end
            old = phase_off;
            n++;
         end
      end
      chk("R8", "servo moves seen", n, 10);
      repeat (300) @(negedge clk);
      dd = theta - phase_off;
      di = int'(dd);
      chk("R8", "residual within floor", (di <= 8 && di >= -8), 1);
      chk("R10", "final correction size", (last_corr == 16 || last_corr == -16), 1);
      wait_run_low();

      // R7 Q equal to zero holds
      place(16'h2000);
      theta = 16'h2000;
      start_servo(0, 16'd256, 16'd16, 100, 0);
      repeat (200) @(negedge clk);
      chk("R7", "zero Q holds phase", phase_off, 16'h2000);
      wait_run_low();

      // R9 weak signal holds
      place(16'h6000);
      theta = 16'h6000 + 16'd200; amp = 50;
      start_servo(0, 16'd256, 16'd16, 100, 0);
      repeat (200) @(negedge clk);
      chk("R9", "weak signal holds phase", phase_off, 16'h6000);
      wait_run_low();

      // R6 all windows overloaded in servo
      amp = 10000;
      start_servo(0, 16'd256, 16'd16, 100, 100);
      repeat (200) @(negedge clk);
      chk("R6", "overload holds servo", phase_off, 16'h6000);
      wait_run_low();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule